// File: doc/BRIEF.md
# NAND ECC Syndrome Corrector

This block judges one flash sector from two packed 24-bit Hamming parity codes. One code was read back from the spare area. The other was computed over the data just read. A start strobe captures both codes. One clock later the block gives a status code with a one-cycle valid pulse. For a correctable error it also gives the 9-bit byte offset and the 3-bit bit index of the flipped data bit.

Equal codes mean the sector is clean. A stored code of all ones together with a computed code of all zeros is the signature of an erased page, and that case is also reported clean. Otherwise the two codes are XORed and reordered into a 24-bit syndrome. A syndrome carrying exactly twelve ones marks a single-bit data error. Every other weight is uncorrectable.

A small repair port lets the caller stream the faulty byte through the block. When the presented byte address matches the located offset, the located bit is flipped.

Top module: `necc_corrector`

## Requirements
- R1: When `storedCode` equals `calcCode` at a start, the status becomes clean (2'b00).
- R2: The raw difference d = storedCode ^ calcCode is reordered into syndrome s as follows: s[5:0] = d[23:18], s[13:6] = d[7:0], s[21:14] = d[15:8], s[22] = d[16], s[23] = d[17].
- R3: A syndrome with exactly 12 bits set gives status corrected (2'b01).
- R4: With status corrected, `errOffset` = {s23,s21,s19,s17,s15,s13,s11,s9,s7} (s23 as MSB) and `errBit` = {s5,s3,s1} (s5 as MSB).
- R5: Any other non-zero syndrome weight, including 1, gives status uncorrectable (2'b10), unless R6 applies.
- R6: A stored code of 24'hFFFFFF with a computed code of 24'h000000 is an erased page, and the status is clean. This rule takes priority over R5.
- R7: `resValid` pulses high for exactly the one cycle after a cycle with `start` high. The results are updated at that same clock edge.
- R8: Status, offset and bit index hold their values until the next start.
- R9: When the status is not corrected, `errOffset` and `errBit` are zero.
- R10: After reset, `resValid` is 0, the status is clean, and offset and bit index are zero.
- R11: `fixByteOut` equals `fixByteIn` with bit `errBit` inverted when the status is corrected and `fixAddr` equals `errOffset`. In every other case it passes `fixByteIn` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the two codes this cycle |
| storedCode | input | 24 | Code read from spare area, byte 0 in bits 7:0 |
| calcCode | input | 24 | Code computed over the read data |
| resValid | output | 1 | One-cycle result strobe |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| errOffset | output | 9 | Byte offset of the single-bit error |
| errBit | output | 3 | Bit index within that byte |
| fixAddr | input | 9 | Address of the byte presented for repair |
| fixByteIn | input | 8 | Data byte to repair |
| fixByteOut | output | 8 | Repaired or passed-through byte |

## Verification
If the syndrome is reordered wrongly, the error shows at the ports one cycle after the start, in the same result pulse. Some errors give the wrong status, for example a weight-12 pattern that is not recognised. Others give a location whose bits no longer follow the odd syndrome positions. A wrong erased-page priority shows as an uncorrectable status for the all-ones/all-zeros pair. A result register that is not held shows as changed outputs on the idle cycle that follows the valid pulse. A fault in the repair gating shows as a flipped bit on a byte whose address does not match, or on a result that is not corrected.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_UNCORR = 2'b10
  } eccStatus_t;

  typedef struct packed {
    logic capture;
  } eccCtrl_t;
endpackage

// File: rtl/necc_control.sv
module necc_control
  import necc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output eccCtrl_t ctrl,
  output logic     resValid
);
  logic validQ;

  always_comb ctrl.capture = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= start;
  end

  assign resValid = validQ;
endmodule

// File: rtl/necc_datapath.sv
module necc_datapath
  import necc_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int OFF_W  = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eccCtrl_t          ctrl,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CODE_W-1:0] calcCode,
  output eccStatus_t        statusQ,
  output logic [OFF_W-1:0]  offsetQ,
  output logic [BIT_W-1:0]  bitQ,
  input  logic [OFF_W-1:0]  fixAddr,
  input  logic [DATA_W-1:0] fixByteIn,
  output logic [DATA_W-1:0] fixByteOut
);
  localparam int WT_W        = $clog2(CODE_W + 1);
  localparam int CORR_WEIGHT = CODE_W / 2;
  localparam int OFF_BASE    = 2 * BIT_W + 1;

  logic [CODE_W-1:0] rawDiff;
  logic [CODE_W-1:0] syn;
  logic [WT_W-1:0]   weight;
  logic [OFF_W-1:0]  offsetNext;
  logic [BIT_W-1:0]  bitNext;
  logic              isErased;
  logic              isEqual;
  eccStatus_t        statusNext;

  assign rawDiff = storedCode ^ calcCode;

  // reorder: byte2[7:2], byte0, byte1, byte2[1:0]
  always_comb begin
    syn[5:0]   = rawDiff[23:18];
    syn[13:6]  = rawDiff[7:0];
    syn[21:14] = rawDiff[15:8];
    syn[22]    = rawDiff[16];
    syn[23]    = rawDiff[17];
  end

  always_comb begin
    weight = '0;
    for (int i = 0; i < CODE_W; i++) weight = weight + WT_W'(syn[i]);
  end

  genvar g;
  generate
    for (g = 0; g < OFF_W; g++) begin : g_off
      assign offsetNext[g] = syn[OFF_BASE + 2 * g];
    end
    for (g = 0; g < BIT_W; g++) begin : g_bit
      assign bitNext[g] = syn[1 + 2 * g];
    end
  endgenerate

  assign isEqual  = (storedCode == calcCode);
  assign isErased = (&storedCode) && !(|calcCode);

  always_comb begin
    if (isEqual || isErased)               statusNext = ST_CLEAN;
    else if (weight == WT_W'(CORR_WEIGHT)) statusNext = ST_FIXED;
    else                                   statusNext = ST_UNCORR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= ST_CLEAN;
      offsetQ <= '0;
      bitQ    <= '0;
    end else if (ctrl.capture) begin
      statusQ <= statusNext;
      if (statusNext == ST_FIXED) begin
        offsetQ <= offsetNext;
        bitQ    <= bitNext;
      end else begin
        offsetQ <= '0;
        bitQ    <= '0;
      end
    end
  end

  logic [DATA_W-1:0] flipMask;
  always_comb begin
    flipMask = '0;
    if (statusQ == ST_FIXED && fixAddr == offsetQ) flipMask[bitQ] = 1'b1;
  end
  assign fixByteOut = fixByteIn ^ flipMask;
endmodule

// File: rtl/necc_corrector.sv
module necc_corrector
  import necc_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int OFF_W  = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CODE_W-1:0] calcCode,
  output logic              resValid,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  errOffset,
  output logic [BIT_W-1:0]  errBit,
  input  logic [OFF_W-1:0]  fixAddr,
  input  logic [DATA_W-1:0] fixByteIn,
  output logic [DATA_W-1:0] fixByteOut
);
  eccCtrl_t   ctrl;
  eccStatus_t statusQ;

  necc_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .resValid(resValid)
  );

  necc_datapath #(.CODE_W(CODE_W), .OFF_W(OFF_W), .BIT_W(BIT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .storedCode(storedCode), .calcCode(calcCode),
    .statusQ(statusQ), .offsetQ(errOffset), .bitQ(errBit),
    .fixAddr(fixAddr), .fixByteIn(fixByteIn), .fixByteOut(fixByteOut)
  );

  assign status = statusQ;
endmodule

// File: rtl/necc_corrector_chk.sv
module necc_corrector_chk #(
  parameter int CODE_W = 24,
  parameter int OFF_W  = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] storedCode,
  input logic [CODE_W-1:0] calcCode,
  input logic              resValid,
  input logic [1:0]        status,
  input logic [OFF_W-1:0]  errOffset,
  input logic [BIT_W-1:0]  errBit,
  input logic [OFF_W-1:0]  fixAddr,
  input logic [DATA_W-1:0] fixByteIn,
  input logic [DATA_W-1:0] fixByteOut
);
  a_r1_equal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    start && storedCode == calcCode |=> status == 2'b00);

  a_r6_erased_clean: assert property (@(posedge clk) disable iff (!rst_n)
    start && (&storedCode) && !(|calcCode) |=> status == 2'b00);

  a_r3_weight_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    start && $countones(storedCode ^ calcCode) == CODE_W / 2 |=> status == 2'b01);

  a_r5_single_uncorr: assert property (@(posedge clk) disable iff (!rst_n)
    start && $countones(storedCode ^ calcCode) == 1 |=> status == 2'b10);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> resValid);

  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !resValid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status) && $stable(errOffset) && $stable(errBit));

  a_r9_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b01 |-> errOffset == '0 && errBit == '0);

  a_r11_fix_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b01 && fixAddr == errOffset |-> $countones(fixByteIn ^ fixByteOut) == 1);

  a_r11_fix_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !(status == 2'b01 && fixAddr == errOffset) |-> fixByteOut == fixByteIn);

  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
endmodule

bind necc_corrector necc_corrector_chk #(
  .CODE_W(CODE_W), .OFF_W(OFF_W), .BIT_W(BIT_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .storedCode(storedCode),
  .calcCode(calcCode), .resValid(resValid), .status(status),
  .errOffset(errOffset), .errBit(errBit), .fixAddr(fixAddr),
  .fixByteIn(fixByteIn), .fixByteOut(fixByteOut)
);

// File: tb/necc_corrector_tb_top.sv
module necc_corrector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] storedCode = '0;
  logic [23:0] calcCode = '0;
  logic        resValid;
  logic [1:0]  status;
  logic [8:0]  errOffset;
  logic [2:0]  errBit;
  logic [8:0]  fixAddr = '0;
  logic [7:0]  fixByteIn = '0;
  logic [7:0]  fixByteOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  necc_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .storedCode(storedCode),
    .calcCode(calcCode), .resValid(resValid), .status(status),
    .errOffset(errOffset), .errBit(errBit), .fixAddr(fixAddr),
    .fixByteIn(fixByteIn), .fixByteOut(fixByteOut)
  );

  task automatic check(string req, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // R2 reorder, written from the requirement
  function automatic logic [23:0] toSyn(logic [23:0] d);
    logic [23:0] s;
    for (int i = 0; i < 6; i++) s[i] = d[18 + i];
    for (int i = 0; i < 8; i++) s[6 + i] = d[i];
    for (int i = 0; i < 8; i++) s[14 + i] = d[8 + i];
    s[22] = d[16];
    s[23] = d[17];
    return s;
  endfunction

  function automatic logic [23:0] fromSyn(logic [23:0] s);
    logic [23:0] d;
    for (int i = 0; i < 24; i++) if (toSyn(24'(1) << i) != '0) begin end
    for (int i = 0; i < 6; i++) d[18 + i] = s[i];
    for (int i = 0; i < 8; i++) d[i] = s[6 + i];
    for (int i = 0; i < 8; i++) d[8 + i] = s[14 + i];
    d[16] = s[22];
    d[17] = s[23];
    return d;
  endfunction

  function automatic void model(input logic [23:0] st, input logic [23:0] ca,
                                output int expStat, output int expOff, output int expBit);
    logic [23:0] s;
    int w;
    s = toSyn(st ^ ca);
    w = 0;
    for (int i = 0; i < 24; i++) w += s[i];
    expOff = 0;
    expBit = 0;
    if (st == ca || (st == 24'hFFFFFF && ca == 24'h000000)) expStat = 0;
    else if (w == 12) begin
      expStat = 1;
      for (int i = 0; i < 9; i++) expOff |= int'(s[7 + 2 * i]) << i;
      for (int i = 0; i < 3; i++) expBit |= int'(s[1 + 2 * i]) << i;
    end else expStat = 2;
  endfunction

  // syndrome of a genuine single data-bit error at (off, bit)
  function automatic logic [23:0] singleErrSyn(int off, int bitIdx);
    logic [23:0] s;
    for (int i = 0; i < 3; i++) begin
      s[1 + 2 * i] = bitIdx[i];
      s[2 * i]     = ~bitIdx[i];
    end
    for (int i = 0; i < 9; i++) begin
      s[7 + 2 * i] = off[i];
      s[6 + 2 * i] = ~off[i];
    end
    return s;
  endfunction

  task automatic runCase(string tag, logic [23:0] st, logic [23:0] ca);
    int eS, eO, eB;
    logic [7:0] b;
    model(st, ca, eS, eO, eB);
    @(negedge clk);
    storedCode = st;
    calcCode = ca;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    storedCode = $urandom;
    calcCode = $urandom;
    check({tag, " R7 valid"}, int'(resValid), 1);
    check({tag, " status R1/R3/R5/R6"}, int'(status), eS);
    check({tag, " offset R4/R9"}, int'(errOffset), eO);
    check({tag, " bit R4/R9"}, int'(errBit), eB);
    b = 8'($urandom);
    fixByteIn = b;
    fixAddr = 9'(eO);
    #1;
    check({tag, " fix R11"}, int'(fixByteOut), (eS == 1) ? int'(b ^ (8'd1 << eB)) : int'(b));
    fixAddr = 9'(eO) ^ 9'(1 + ($urandom % 511));
    #1;
    check({tag, " fix other addr R11"}, int'(fixByteOut), int'(b));
    @(negedge clk);
    check({tag, " R7 pulse ends"}, int'(resValid), 0);
    check({tag, " R8 hold status"}, int'(status), eS);
    check({tag, " R8 hold offset"}, int'(errOffset), eO);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(resValid), 0);
    check("R10 reset status", int'(status), 0);
    check("R10 reset offset", int'(errOffset), 0);
    check("R10 reset bit", int'(errBit), 0);
    rst_n = 1'b1;

    runCase("R1 equal", 24'h3C5A96, 24'h3C5A96);
    runCase("R6 erased", 24'hFFFFFF, 24'h000000);
    runCase("R5 single syndrome bit", 24'h123456, 24'h123457);
    runCase("R3 first byte bit0", 24'h0F0F0F, 24'h0F0F0F ^ fromSyn(singleErrSyn(0, 0)));
    runCase("R4 last byte bit7", 24'hA5A5A5, 24'hA5A5A5 ^ fromSyn(singleErrSyn(511, 7)));
    runCase("R2 mid location", 24'h000000, fromSyn(singleErrSyn(9'h155, 5)));
    runCase("R5 all ones diff", 24'h000000, 24'hFFFFFF);
    runCase("R6 not erased", 24'hFFFFFF, 24'h000001);

    for (int n = 0; n < 300; n++) begin
      r = 24'($urandom);
      case ($urandom % 4)
        0: runCase("R3 rand fix", r, r ^ fromSyn(singleErrSyn(int'($urandom % 512), int'($urandom % 8))));
        1: runCase("R1 rand eq", r, r);
        2: runCase("R5 rand one", r, r ^ (24'd1 << ($urandom % 24)));
        default: runCase("R5 rand any", r, 24'($urandom));
      endcase
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule